// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Unit

This block sits between a 32-bit register datapath and a byte-addressed, 32-bit-wide memory bus. Each request carries an index register value, an addressing mode, an access size (byte, halfword or longword), a sign flag, a direction and write data. The block forms the effective address and checks it for alignment. It then issues one bus cycle with active-high byte enables and the data moved into the right lanes, and it returns the stepped index value to write back. Packed data is big-endian: the lowest byte address within a longword is the most significant lane.

When the bus returns read data for a load, the block selects the addressed byte or halfword and produces a 32-bit result. That result is either zero-extended or sign-extended. An access whose address does not match its size, or one that uses the reserved size code, raises a fault pulse. A faulted access issues no bus cycle and writes no index. All request-side outputs are registered and appear one clock after the request. The load result is registered and appears one clock after the read data.

Top module: `sll_lane_unit`

## Requirements
- R1: After synchronous reset, mem_req, ld_valid, idx_wr and align_fault are all low.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = longword, and 3 is reserved. One clock after req_valid, an aligned access raises mem_req for one cycle with mem_we = req_store, and mem_addr is the effective address with bits [1:0] cleared. A byte store at address offset k (k = effective address bits [1:0]) sets only mem_be bit 3-k and places req_wdata[7:0] in mem_wdata bits [31-8k:24-8k], with all other lanes zero.
- R3: A halfword store at offset 0 drives mem_be = 4'b1100 with req_wdata[15:0] in bits [31:16]. At offset 2 it drives mem_be = 4'b0011 with req_wdata[15:0] in bits [15:0]. Unselected lanes are zero.
- R4: A longword store drives mem_be = 4'b1111 and passes req_wdata unchanged.
- R5: A load with req_signed = 0 returns the addressed byte or halfword (using the same lane mapping as stores) with all higher bits zero. A longword load returns the bus word unchanged.
- R6: A byte or halfword load with req_signed = 1 fills all bits above the selected field with that field's top bit.
- R7: A halfword at an odd address, a longword whose address is not a multiple of 4, or size code 3 pulses align_fault one clock after the request. Such an access raises no mem_req and does not change the context used for the next load result.
- R8: Mode 1 (post-increment) uses the index as the effective address and, one clock later, pulses idx_wr with idx_next = index + 1, 2 or 4 according to size.
- R9: Mode 2 (pre-decrement) uses index - 1, 2 or 4 as the effective address and pulses idx_wr with idx_next equal to that address.
- R10: Mode 0 (and the reserved mode 3) uses the index unchanged as the address and leaves idx_wr low. A faulted access never raises idx_wr.
- R11: One clock after mem_rvalid, ld_valid pulses and ld_data holds the extracted value of the most recent load that reached the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_mode | input | 2 | Index addressing mode |
| req_index | input | ADDR_W | Index register value |
| req_wdata | input | 32 | Store data, right-justified |
| mem_req | output | 1 | Bus cycle strobe |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | ADDR_W | Longword-aligned bus address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| idx_wr | output | 1 | Index write-back strobe |
| idx_next | output | ADDR_W | Stepped index value |
| align_fault | output | 1 | Misaligned or reserved-size access |

## Verification
The hardest case to reach is a faulted load that arrives between a good load and that load's read data. If the block let the fault touch the stored lane context, the returned value would be extracted with the wrong size and offset. The bench issues a signed byte load at offset 1, then a misaligned halfword load, and only then returns the read data. It expects the sign-extended byte from lane 2. Pre-decrement is also driven across a longword boundary, so that the bus address, the enables and the written-back index all come from the stepped address and not from the original index.

// File: rtl/sll_pkg.sv
package sll_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        IX_NONE    = 2'd0,
        IX_POSTINC = 2'd1,
        IX_PREDEC  = 2'd2,
        IX_RSVD    = 2'd3
    } idx_mode_e;

    typedef struct packed {
        acc_size_e        size;
        logic             sext;
        logic [OFS_W-1:0] ofs;
    } ld_ctx_t;

    function automatic logic [OFS_W:0] size_bytes(acc_size_e sz);
        case (sz)
            SZ_BYTE: return (OFS_W+1)'(1);
            SZ_HALF: return (OFS_W+1)'(2);
            default: return (OFS_W+1)'(LANES);
        endcase
    endfunction

    // Lane i carries address offset LANES-1-i (big-endian packing).
    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFS_W-1:0] ofs);
        logic [LANES-1:0] m;
        int nb;
        m  = '0;
        nb = int'(size_bytes(sz));
        for (int i = 0; i < LANES; i++) begin
            if ((LANES - 1 - i) >= int'(ofs) && (LANES - 1 - i) < int'(ofs) + nb)
                m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sll_addr_step.sv
module sll_addr_step
    import sll_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] index_i,
    input  idx_mode_e         mode_i,
    input  acc_size_e         size_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] next_o,
    output logic              upd_o,
    output logic              misalign_o
);

    logic [OFS_W:0]    nb;
    logic [ADDR_W-1:0] step;
    logic [OFS_W-1:0]  low_mask;

    assign nb       = size_bytes(size_i);
    assign step     = ADDR_W'(nb);
    assign low_mask = nb[OFS_W-1:0] - OFS_W'(1);

    always_comb begin
        case (mode_i)
            IX_POSTINC: begin
                ea_o   = index_i;
                next_o = index_i + step;
                upd_o  = 1'b1;
            end
            IX_PREDEC: begin
                ea_o   = index_i - step;
                next_o = index_i - step;
                upd_o  = 1'b1;
            end
            default: begin
                ea_o   = index_i;
                next_o = index_i;
                upd_o  = 1'b0;
            end
        endcase
    end

    assign misalign_o = (size_i == SZ_RSVD) || ((ea_o[OFS_W-1:0] & low_mask) != '0);

endmodule

// File: rtl/sll_store_lanes.sv
module sll_store_lanes
    import sll_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] lane_data_o
);

    logic [OFS_W:0] nb;

    assign nb   = size_bytes(size_i);
    assign be_o = lane_mask(size_i, ofs_i);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int LANE_POS = LANES - 1 - gi;
        logic [7:0] byte_d;

        always_comb begin
            int src;
            src = int'(nb) - 1 - LANE_POS + int'(ofs_i);
            if (be_o[gi])
                byte_d = wdata_i[8*(src & (LANES-1)) +: 8];
            else
                byte_d = 8'h00;
        end

        assign lane_data_o[8*gi +: 8] = byte_d;
    end

endmodule

// File: rtl/sll_load_extract.sv
module sll_load_extract
    import sll_pkg::*;
(
    input  ld_ctx_t           ctx_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] value_o
);

    always_comb begin
        int sh;
        logic [DATA_W-1:0] raw;
        sh = (LANES - int'(size_bytes(ctx_i.size)) - int'(ctx_i.ofs)) * 8;
        if (sh < 0)
            sh = 0;
        raw = rdata_i >> sh;
        case (ctx_i.size)
            SZ_BYTE: value_o = {{(DATA_W-8){ctx_i.sext & raw[7]}}, raw[7:0]};
            SZ_HALF: value_o = {{(DATA_W-16){ctx_i.sext & raw[15]}}, raw[15:0]};
            default: value_o = raw;
        endcase
    end

endmodule

// File: rtl/sll_lane_unit.sv
module sll_lane_unit
    import sll_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_index,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              idx_wr,
    output logic [ADDR_W-1:0] idx_next,
    output logic              align_fault
);

    acc_size_e         size_c;
    idx_mode_e         mode_c;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] nx;
    logic              upd;
    logic              misalign;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] lane_c;
    logic [DATA_W-1:0] ext_c;
    logic              issue;
    ld_ctx_t           ctx_q;

    assign size_c = acc_size_e'(req_size);
    assign mode_c = idx_mode_e'(req_mode);

    sll_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .index_i    (req_index),
        .mode_i     (mode_c),
        .size_i     (size_c),
        .ea_o       (ea),
        .next_o     (nx),
        .upd_o      (upd),
        .misalign_o (misalign)
    );

    sll_store_lanes u_store (
        .size_i      (size_c),
        .ofs_i       (ea[OFS_W-1:0]),
        .wdata_i     (req_wdata),
        .be_o        (be_c),
        .lane_data_o (lane_c)
    );

    sll_load_extract u_load (
        .ctx_i   (ctx_q),
        .rdata_i (mem_rdata),
        .value_o (ext_c)
    );

    assign issue = req_valid && !misalign;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req     <= 1'b0;
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_be      <= '0;
            mem_wdata   <= '0;
            align_fault <= 1'b0;
            idx_wr      <= 1'b0;
            idx_next    <= '0;
            ld_valid    <= 1'b0;
            ld_data     <= '0;
            ctx_q       <= '{size: SZ_WORD, sext: 1'b0, ofs: '0};
        end else begin
            mem_req     <= issue;
            mem_we      <= issue && req_store;
            mem_addr    <= {ea[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            mem_be      <= issue ? be_c : '0;
            mem_wdata   <= (issue && req_store) ? lane_c : '0;
            align_fault <= req_valid && misalign;
            idx_wr      <= issue && upd;
            idx_next    <= nx;
            ld_valid    <= mem_rvalid;
            if (mem_rvalid)
                ld_data <= ext_c;
            if (issue && !req_store)
                ctx_q <= '{size: size_c, sext: req_signed, ofs: ea[OFS_W-1:0]};
        end
    end

endmodule

// File: rtl/sll_lane_chk.sv
module sll_lane_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              mem_rvalid,
    input logic              ld_valid,
    input logic              idx_wr,
    input logic              align_fault
);

    logic [31:0] be_bits;

    always_comb begin
        for (int i = 0; i < 4; i++)
            be_bits[8*i +: 8] = {8{mem_be[i]}};
    end

    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00); // R2

    AST_STORE_LANES_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata & ~be_bits) == 32'h0); // R2

    AST_HALF_LANE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $countones(mem_be) == 2) |-> (mem_be == 4'b1100 || mem_be == 4'b0011)); // R3

    AST_STROBE_HAS_LANES: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R4

    AST_FAULT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !mem_req); // R7

    AST_FAULT_NO_INDEX: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !idx_wr); // R10

    AST_RESULT_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(mem_rvalid)); // R11

endmodule

bind sll_lane_unit sll_lane_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_rvalid  (mem_rvalid),
    .ld_valid    (ld_valid),
    .idx_wr      (idx_wr),
    .align_fault (align_fault)
);

// File: tb/sll_lane_unit_tb.sv
module sll_lane_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [31:0] req_index = 32'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        idx_wr;
    logic [31:0] idx_next;
    logic        align_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sll_lane_unit #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
        .req_signed(req_signed), .req_mode(req_mode), .req_index(req_index),
        .req_wdata(req_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data),
        .idx_wr(idx_wr), .idx_next(idx_next), .align_fault(align_fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0: return 4'b1000 >> off;
            2'd1: return (off == 2'd0) ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_st(input logic [1:0] sz, input logic [1:0] off,
                                           input logic [31:0] wd);
        case (sz)
            2'd0: return {wd[7:0], 24'h0} >> (8 * off);
            2'd1: return (off == 2'd0) ? {wd[15:0], 16'h0} : {16'h0, wd[15:0]};
            default: return wd;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] off,
                                           input bit sg, input logic [31:0] rd);
        logic [31:0] sh;
        sh = rd << (8 * off);
        case (sz)
            2'd0: return sg ? {{24{sh[31]}}, sh[31:24]} : {24'h0, sh[31:24]};
            2'd1: return sg ? {{16{sh[31]}}, sh[31:16]} : {16'h0, sh[31:16]};
            default: return rd;
        endcase
    endfunction

    // Presents one request for one cycle; returns at the negedge after the capturing edge.
    task automatic issue(input bit st, input logic [1:0] sz, input bit sg,
                         input logic [1:0] md, input logic [31:0] ix, input logic [31:0] wd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_store  = st;
        req_size   = sz;
        req_signed = sg;
        req_mode   = md;
        req_index  = ix;
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic respond(input logic [31:0] rd);
        mem_rvalid = 1'b1;
        mem_rdata  = rd;
        @(negedge clk);
        mem_rvalid = 1'b0;
    endtask

    task automatic t_reset;
        chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'h0);
        chk(ld_valid == 1'b0, "R1", "ld_valid", 32'(ld_valid), 32'h0);
        chk(idx_wr == 1'b0, "R1", "idx_wr", 32'(idx_wr), 32'h0);
        chk(align_fault == 1'b0, "R1", "align_fault", 32'(align_fault), 32'h0);
    endtask

    task automatic t_store_bytes;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] wd;
            wd = 32'hA5B6C7D8 + 32'(k);
            issue(1'b1, 2'd0, 1'b0, 2'd0, 32'h100 + 32'(k), wd);
            chk(mem_req && mem_we, "R2", "byte store strobe", {mem_req, mem_we}, 2'b11);
            chk(mem_addr == 32'h100, "R2", "byte store addr", mem_addr, 32'h100);
            chk(mem_be == exp_be(2'd0, 2'(k)), "R2", "byte store be", 32'(mem_be), 32'(exp_be(2'd0, 2'(k))));
            chk(mem_wdata == exp_st(2'd0, 2'(k), wd), "R2", "byte store data", mem_wdata, exp_st(2'd0, 2'(k), wd));
        end
    endtask

    task automatic t_store_halves;
        for (int k = 0; k < 4; k += 2) begin
            issue(1'b1, 2'd1, 1'b0, 2'd0, 32'h204 + 32'(k), 32'h1234ABCD);
            chk(mem_addr == 32'h204, "R3", "half store addr", mem_addr, 32'h204);
            chk(mem_be == exp_be(2'd1, 2'(k)), "R3", "half store be", 32'(mem_be), 32'(exp_be(2'd1, 2'(k))));
            chk(mem_wdata == exp_st(2'd1, 2'(k), 32'h1234ABCD), "R3", "half store data",
                mem_wdata, exp_st(2'd1, 2'(k), 32'h1234ABCD));
        end
    endtask

    task automatic t_store_word;
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h308, 32'hDEADBEEF);
        chk(mem_be == 4'b1111, "R4", "word store be", 32'(mem_be), 32'hF);
        chk(mem_wdata == 32'hDEADBEEF, "R4", "word store data", mem_wdata, 32'hDEADBEEF);
    endtask

    task automatic t_loads;
        logic [31:0] rd;
        rd = 32'h81F27C03;
        for (int sg = 0; sg < 2; sg++) begin
            for (int k = 0; k < 4; k++) begin
                issue(1'b0, 2'd0, sg[0], 2'd0, 32'h400 + 32'(k), 32'h0);
                chk(mem_req && !mem_we, "R5", "byte load strobe", {mem_req, mem_we}, 2'b10);
                respond(rd);
                chk(ld_valid == 1'b1, "R11", "ld_valid", 32'(ld_valid), 32'h1);
                chk(ld_data == exp_ld(2'd0, 2'(k), sg[0], rd), sg[0] ? "R6" : "R5", "byte load",
                    ld_data, exp_ld(2'd0, 2'(k), sg[0], rd));
            end
            for (int k = 0; k < 4; k += 2) begin
                issue(1'b0, 2'd1, sg[0], 2'd0, 32'h400 + 32'(k), 32'h0);
                respond(rd);
                chk(ld_data == exp_ld(2'd1, 2'(k), sg[0], rd), sg[0] ? "R6" : "R5", "half load",
                    ld_data, exp_ld(2'd1, 2'(k), sg[0], rd));
            end
        end
        issue(1'b0, 2'd2, 1'b1, 2'd0, 32'h400, 32'h0);
        respond(rd);
        chk(ld_data == rd, "R5", "word load", ld_data, rd);
        chk(ld_valid == 1'b1, "R11", "ld_valid word", 32'(ld_valid), 32'h1);
        @(negedge clk);
        chk(ld_valid == 1'b0, "R11", "ld_valid single pulse", 32'(ld_valid), 32'h0);
    endtask

    task automatic t_misaligned;
        issue(1'b1, 2'd1, 1'b0, 2'd0, 32'h201, 32'hFFFF);
        chk(align_fault && !mem_req, "R7", "odd half store", {align_fault, mem_req}, 2'b10);
        issue(1'b0, 2'd2, 1'b0, 2'd0, 32'h202, 32'h0);
        chk(align_fault && !mem_req, "R7", "word at offset 2", {align_fault, mem_req}, 2'b10);
        issue(1'b1, 2'd3, 1'b0, 2'd0, 32'h200, 32'h0);
        chk(align_fault && !mem_req, "R7", "reserved size", {align_fault, mem_req}, 2'b10);
        // good signed byte load at offset 1, then a faulted half load, then the data
        issue(1'b0, 2'd0, 1'b1, 2'd0, 32'h301, 32'h0);
        chk(!align_fault && mem_req, "R7", "good load no fault", {align_fault, mem_req}, 2'b01);
        issue(1'b0, 2'd1, 1'b0, 2'd0, 32'h303, 32'h0);
        chk(align_fault, "R7", "faulted load", 32'(align_fault), 32'h1);
        respond(32'h12F45678);
        chk(ld_data == 32'hFFFFFFF4, "R7", "context kept across fault", ld_data, 32'hFFFFFFF4);
    endtask

    task automatic t_index;
        issue(1'b1, 2'd2, 1'b0, 2'd1, 32'h1000, 32'h0);
        chk(mem_addr == 32'h1000, "R8", "post-inc word addr", mem_addr, 32'h1000);
        chk(idx_wr && idx_next == 32'h1004, "R8", "post-inc word index", idx_next, 32'h1004);
        issue(1'b0, 2'd0, 1'b0, 2'd1, 32'h1003, 32'h0);
        chk(mem_be == 4'b0001, "R8", "post-inc byte be", 32'(mem_be), 32'h1);
        chk(idx_wr && idx_next == 32'h1004, "R8", "post-inc byte index", idx_next, 32'h1004);
        issue(1'b1, 2'd1, 1'b0, 2'd2, 32'h2000, 32'h5A5A);
        chk(mem_addr == 32'h1FFC && mem_be == 4'b0011, "R9", "pre-dec half addr/be",
            {mem_addr[27:0], mem_be}, {28'h1FFC, 4'b0011});
        chk(mem_wdata == 32'h00005A5A, "R9", "pre-dec half data", mem_wdata, 32'h00005A5A);
        chk(idx_wr && idx_next == 32'h1FFE, "R9", "pre-dec half index", idx_next, 32'h1FFE);
        issue(1'b0, 2'd2, 1'b0, 2'd2, 32'h3000, 32'h0);
        chk(mem_addr == 32'h2FFC && idx_next == 32'h2FFC, "R9", "pre-dec word", idx_next, 32'h2FFC);
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h5000, 32'h0);
        chk(mem_req && !idx_wr && mem_addr == 32'h5000, "R10", "mode 0 no index write",
            {mem_req, idx_wr}, 2'b10);
        issue(1'b1, 2'd0, 1'b0, 2'd3, 32'h5001, 32'h0);
        chk(mem_req && !idx_wr && mem_be == 4'b0100, "R10", "mode 3 no index write",
            {mem_req, idx_wr}, 2'b10);
        issue(1'b1, 2'd1, 1'b0, 2'd1, 32'h401, 32'h0);
        chk(align_fault && !idx_wr, "R10", "fault blocks index write", {align_fault, idx_wr}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_store_bytes();
        t_store_halves();
        t_store_word();
        t_loads();
        t_misaligned();
        t_index();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule